// File: doc/BRIEF.md
# SPI Serial Memory Slave with Region Locking

This block is an SPI slave that serves a 2048-byte memory held in registers. An SPI master talks to it over four pins: chip select, serial clock, data in and data out. The master can read the memory, send bytes for a write, and read or change an eight-bit status register. A slow write cycle is modelled by a counter that runs for a set number of clock cycles.

All serial inputs pass through a synchronizer clocked by a system clock, which must run at least eight times faster than the serial clock. A write command first fills a one-page buffer of 32 bytes. When chip select rises, the buffer is committed to the array, but only after the timed busy period has run.

Two status bits lock a region at the top of the array: a quarter, a half, or the whole of it. An active-low hold-off pin can freeze the status register, but only when the status register's own freeze-enable bit is set.

Top module: `spi_nvm_slave`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes only after falling SCK edges. Both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) work.
- R2: so_en_o is 0 while cs_ni is high (SO released) and 1 while cs_ni is low.
- R3: Command 0x03 is followed by two address bytes, high byte first. Only the low 11 bits of the address are used; the top 5 bits are ignored. Data bytes then stream out MSB first from consecutive addresses, and the address wraps from 0x7FF to 0x000.
- R4: Status byte layout: bit0 = busy, bit1 = write-enable latch, bits 3:2 = lock code, bit7 = freeze-enable, all other bits 0. Command 0x06 sets the latch and 0x04 clears it. Command 0x05 returns the status byte, and repeats it for every further byte clocked.
- R5: A write (0x02) or status write (0x01) sent while the write-enable latch is clear is ignored. No busy period starts and nothing changes.
- R6: A write takes data bytes into a 32-byte page buffer. The in-page offset wraps, so byte k goes to offset (start offset + k) mod 32 within the same page. The buffer is committed only if chip select rises on a byte boundary after at least one data byte.
- R7: A committed write or status write sets the busy bit for WRITE_CYCLES clock cycles. At the end of that period the array or status register is updated, and both the busy bit and the write-enable latch clear.
- R8: While busy, only command 0x05 is acted on. Every other command is dropped: SO stays high and no new write or busy period results.
- R9: Lock code 00 locks nothing, 01 locks 0x600-0x7FF, 10 locks 0x400-0x7FF, and 11 locks the whole array. Bytes aimed at locked addresses are discarded, but the busy period still runs.
- R10: A status write ends with no effect when wp_ni is low and the freeze-enable bit is set. The latch stays set and no busy period starts. When wp_ni is high, status writes are accepted.
- R11: After reset the status byte reads 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data from the master |
| wp_ni | input | 1 | Active-low status-register hold-off |
| so_o | output | 1 | Serial data to the master |
| so_en_o | output | 1 | Output driver enable for SO |

## Verification
The bench builds the block with WRITE_CYCLES set to 1000 instead of the 500000-cycle default. This short busy period lets a status read land inside the busy window, and lets a dropped command be sent during it. Many full write-then-read rounds then fit in the run. The other parameters keep their defaults: an 11-bit address, 32-byte pages and a two-stage synchronizer. With these values the top-of-array wrap, the in-page wrap at a page edge and the boundaries of all four lock codes can all be reached. The serial clock runs at one twelfth of the system clock, close to the minimum ratio the synchronizer needs.

// File: rtl/snvm_pkg.sv
package snvm_pkg;
   typedef enum logic [2:0] {
      S_CMD, S_AHI, S_ALO, S_RD, S_WR, S_WRSR, S_RDSR, S_DROP
   } sstate_e;

   typedef enum logic {C_PAGE, C_STAT} commit_e;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/snvm_sync.sv
module snvm_sync #(
   parameter int          STAGES  = 2,
   parameter int          WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg_q [STAGES];

   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("snvm_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stg_q[s] <= RST_VAL;
         else if (s == 0) stg_q[s] <= d_i;
         else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/snvm_lock.sv
module snvm_lock (
   input  logic [1:0] code_i,
   input  logic [1:0] region_i,
   output logic       locked_o
);
   always_comb begin
      unique case (code_i)
         2'b00:   locked_o = 1'b0;
         2'b01:   locked_o = (region_i == 2'b11);
         2'b10:   locked_o = region_i[1];
         default: locked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/snvm_timer.sv
module snvm_timer #(
   parameter int CYCLES = 500000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   initial begin : p_param_chk
      assert (CYCLES >= 1) else $error("snvm_timer needs CYCLES >= 1");
   end

   assign done_o = busy_o && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_o) begin
         if (cnt_q == LAST) busy_o <= 1'b0;
         cnt_q <= cnt_q + 1'b1;
      end else if (start_i) begin
         busy_o <= 1'b1;
         cnt_q  <= '0;
      end
   end

   p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o);
   p_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
   import snvm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int PAGE_W       = 5,
   parameter int SYNC_STAGES  = 2,
   parameter int WRITE_CYCLES = 500000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cs_ni,
   input  logic sck_i,
   input  logic si_i,
   input  logic wp_ni,
   output logic so_o,
   output logic so_en_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;
   localparam int PG_W  = ADDR_W - PAGE_W;

   initial begin : p_param_chk
      assert (ADDR_W >= 9 && ADDR_W <= 16) else $error("ADDR_W must fit two address bytes");
      assert (PAGE_W >= 1 && PAGE_W <= ADDR_W - 2) else $error("pages must not straddle lock regions");
   end

   // input synchronisation and edge detection
   logic [3:0] sync_q;
   logic       cs_s, sck_s, si_s, wp_s;
   logic       cs_d, sck_d;

   snvm_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b1111)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({cs_ni, sck_i, si_i, wp_ni}),
      .q_o    (sync_q)
   );
   assign {cs_s, sck_s, si_s, wp_s} = sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b1;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   logic sck_rise, sck_fall, cs_fall_e, cs_rise_e;
   assign sck_rise  = !cs_s && !cs_d && sck_s && !sck_d;
   assign sck_fall  = !cs_s && !cs_d && !sck_s && sck_d;
   assign cs_fall_e = cs_d && !cs_s;
   assign cs_rise_e = !cs_d && cs_s;

   // state
   sstate_e            st_q;
   logic [2:0]         bit_q;
   logic [6:0]         rx_q;
   logic [7:0]         tx_q;
   logic               so_q;
   logic               rd_mode_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [PG_W-1:0]    pg_q;
   logic [PAGE_W-1:0]  off_q;
   logic [7:0]         pbuf_q [PAGE];
   logic [PAGE-1:0]    pbuf_v_q;
   logic [7:0]         wrsr_q;
   logic               wrsr_v_q;
   logic               wel_q, wpen_q;
   logic [1:0]         bp_q;
   commit_e            kind_q;
   logic               start_q;
   logic [7:0]         mem_q [DEPTH];

   logic wip, tmr_done, pg_locked;
   logic [7:0] rx_byte, status;
   logic [ADDR_W-1:0] full_addr;

   assign rx_byte   = {rx_q, si_s};
   assign status    = {wpen_q, 3'b000, bp_q, wel_q, wip};
   assign full_addr = {addr_q[ADDR_W-1:8], rx_byte};

   snvm_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_q),
      .busy_o  (wip),
      .done_o  (tmr_done)
   );

   snvm_lock u_lock (
      .code_i   (bp_q),
      .region_i (pg_q[PG_W-1 -: 2]),
      .locked_o (pg_locked)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= S_DROP;
         bit_q     <= '0;
         rx_q      <= '0;
         tx_q      <= 8'hFF;
         so_q      <= 1'b1;
         rd_mode_q <= 1'b0;
         addr_q    <= '0;
         pg_q      <= '0;
         off_q     <= '0;
         pbuf_v_q  <= '0;
         wrsr_q    <= '0;
         wrsr_v_q  <= 1'b0;
         wel_q     <= 1'b0;
         wpen_q    <= 1'b0;
         bp_q      <= 2'b00;
         kind_q    <= C_PAGE;
         start_q   <= 1'b0;
         for (int i = 0; i < PAGE; i++) pbuf_q[i] <= 8'h00;
      end else begin
         start_q <= 1'b0;

         if (tmr_done) begin
            wel_q <= 1'b0;
            if (kind_q == C_STAT) begin
               bp_q   <= wrsr_q[3:2];
               wpen_q <= wrsr_q[7];
            end
         end

         if (cs_s) bit_q <= '0;

         if (cs_fall_e) begin
            st_q     <= S_CMD;
            bit_q    <= '0;
            wrsr_v_q <= 1'b0;
            tx_q     <= 8'hFF;
         end

         if (cs_rise_e && !wip && bit_q == 3'd0) begin
            if (st_q == S_WR && |pbuf_v_q) begin
               start_q <= 1'b1;
               kind_q  <= C_PAGE;
            end else if (wrsr_v_q && !(!wp_s && wpen_q)) begin
               start_q <= 1'b1;
               kind_q  <= C_STAT;
            end
         end

         if (sck_rise) begin
            rx_q  <= rx_byte[6:0];
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
               unique case (st_q)
                  S_CMD: begin
                     tx_q <= 8'hFF;
                     st_q <= S_DROP;
                     if (rx_byte == OP_RDSR) begin
                        st_q <= S_RDSR;
                        tx_q <= status;
                     end else if (!wip) begin
                        if (rx_byte == OP_WREN) wel_q <= 1'b1;
                        if (rx_byte == OP_WRDI) wel_q <= 1'b0;
                        if (rx_byte == OP_WRSR && wel_q) st_q <= S_WRSR;
                        if (rx_byte == OP_READ) begin
                           st_q      <= S_AHI;
                           rd_mode_q <= 1'b1;
                        end
                        if (rx_byte == OP_WRITE && wel_q) begin
                           st_q      <= S_AHI;
                           rd_mode_q <= 1'b0;
                        end
                     end
                  end
                  S_AHI: begin
                     addr_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                     st_q <= S_ALO;
                  end
                  S_ALO: begin
                     if (rd_mode_q) begin
                        tx_q   <= mem_q[full_addr];
                        addr_q <= full_addr + 1'b1;
                        st_q   <= S_RD;
                     end else begin
                        pg_q     <= full_addr[ADDR_W-1:PAGE_W];
                        off_q    <= full_addr[PAGE_W-1:0];
                        pbuf_v_q <= '0;
                        st_q     <= S_WR;
                     end
                  end
                  S_RD: begin
                     tx_q   <= mem_q[addr_q];
                     addr_q <= addr_q + 1'b1;
                  end
                  S_WR: begin
                     pbuf_q[off_q]   <= rx_byte;
                     pbuf_v_q[off_q] <= 1'b1;
                     off_q           <= off_q + 1'b1;
                  end
                  S_WRSR: begin
                     wrsr_q   <= rx_byte;
                     wrsr_v_q <= 1'b1;
                     st_q     <= S_DROP;
                  end
                  S_RDSR: tx_q <= status;
                  default: tx_q <= 8'hFF;
               endcase
            end
         end

         if (sck_fall) so_q <= tx_q[3'd7 - bit_q];
      end
   end

   // storage array, erased to all ones
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (tmr_done && kind_q == C_PAGE && !pg_locked) begin
         for (int i = 0; i < PAGE; i++)
            if (pbuf_v_q[i]) mem_q[{pg_q, PAGE_W'(i)}] <= pbuf_q[i];
      end
   end

   assign so_o    = so_q;
   assign so_en_o = !cs_ni;

   p_so_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sck_fall |=> $stable(so_q));
   p_start_wel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |-> wel_q);
   p_busy_wel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wip && !tmr_done) |=> $stable(wel_q));
   p_locked_page_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_done && kind_q == C_PAGE && pg_locked) |=> $stable(mem_q[{pg_q, PAGE_W'(0)}]));
   p_wp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_rise_e && wrsr_v_q && !wp_s && wpen_q && !wip) |=> !start_q);
endmodule

// File: tb/spi_nvm_slave_tb_top.sv
module spi_nvm_slave_tb_top;
   localparam int WCYC = 1000;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
   logic so, so_en;
   logic mode3 = 1'b0;

   int checks = 0, fails = 0;
   logic [7:0] mdl [2048];
   logic [7:0] dbuf [64];
   logic m_wel = 1'b0;
   logic [1:0] m_bp = 2'b00;

   always #5 clk = ~clk;

   spi_nvm_slave #(.WRITE_CYCLES(WCYC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
      .wp_ni(wp_n), .so_o(so), .so_en_o(so_en)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic locked(input logic [1:0] bp, input logic [10:0] a);
      case (bp)
         2'b00: return 1'b0;
         2'b01: return a >= 11'h600;
         2'b10: return a >= 11'h400;
         default: return 1'b1;
      endcase
   endfunction

   task automatic cs_begin();
      sck = mode3;
      tick(2);
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic cs_end();
      tick(HALF);
      cs_n = 1'b1;
      tick(2 * HALF);
   endtask

   task automatic sbyte(input logic [7:0] d, output logic [7:0] r);
      for (int b = 7; b >= 0; b--) begin
         if (mode3) begin
            sck = 1'b0; si = d[b]; tick(HALF); r[b] = so; sck = 1'b1; tick(HALF);
         end else begin
            si = d[b]; tick(HALF); r[b] = so; sck = 1'b1; tick(HALF); sck = 1'b0;
         end
      end
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      cs_begin(); sbyte(op, r); cs_end();
   endtask

   task automatic wren();
      cmd1(8'h06);
      m_wel = 1'b1;
   endtask

   task automatic rdsr_chk(input string req, input logic [7:0] exp);
      logic [7:0] r;
      cs_begin();
      sbyte(8'h05, r);
      sbyte(8'hFF, r); chk(req, r, exp);
      sbyte(8'hFF, r); chk(req, r, exp);
      cs_end();
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] r;
      cs_begin(); sbyte(8'h01, r); sbyte(v, r); cs_end();
   endtask

   task automatic wr(input logic [10:0] a, input int n);
      logic [7:0] r;
      cs_begin();
      sbyte(8'h02, r); sbyte({5'b0, a[10:8]}, r); sbyte(a[7:0], r);
      for (int i = 0; i < n; i++) begin
         logic [10:0] t;
         sbyte(dbuf[i], r);
         t = {a[10:5], 5'(a[4:0] + 5'(i))};
         if (m_wel && !locked(m_bp, t)) mdl[t] = dbuf[i];
      end
      cs_end();
      if (n > 0) m_wel = 1'b0;
   endtask

   task automatic rd_chk(input logic [10:0] a, input int n, input string req);
      logic [7:0] r;
      cs_begin();
      sbyte(8'h03, r); sbyte({5'b11111, a[10:8]}, r); sbyte(a[7:0], r);
      for (int i = 0; i < n; i++) begin
         sbyte(8'hFF, r);
         chk(req, r, mdl[11'(a + 11'(i))]);
      end
      cs_end();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      for (int i = 0; i < 2048; i++) mdl[i] = 8'hFF;
      void'($urandom(32'h5EED_0042));
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R11 reset state
      rdsr_chk("R11 status after reset", 8'h00);
      rd_chk(11'h123, 2, "R11 erased array");

      // R2 output enable
      chk("R2 so_en idle", so_en, 1'b0);
      cs_begin();
      chk("R2 so_en selected", so_en, 1'b1);
      cs_end();
      chk("R2 so_en released", so_en, 1'b0);

      // R5 commands without the latch
      dbuf[0] = 8'hAB;
      wr(11'h010, 1);
      rdsr_chk("R5 write ignored, no busy", 8'h00);
      wrsr(8'h0C);
      rdsr_chk("R5 status write ignored", 8'h00);
      rd_chk(11'h010, 1, "R5 array untouched");

      // R4 latch set and clear, mode 3
      mode3 = 1'b1;
      wren();
      rdsr_chk("R4 latch set (R1 mode 3)", 8'h02);
      cmd1(8'h04); m_wel = 1'b0;
      rdsr_chk("R4 latch cleared", 8'h00);
      mode3 = 1'b0;

      // R6 page wrap, R7 busy, R8 dropped commands
      wren();
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
      wr(11'h03E, 4);
      rdsr_chk("R7 busy with latch", 8'h03);
      cs_begin();
      sbyte(8'h03, r); sbyte(8'h00, r); sbyte(8'h3E, r); sbyte(8'hFF, r);
      chk("R8 read dropped while busy", r, 8'hFF);
      cs_end();
      cs_begin();
      sbyte(8'h02, r); sbyte(8'h01, r); sbyte(8'h00, r); sbyte(8'h55, r);
      cs_end();
      tick(WCYC + 50);
      rdsr_chk("R7 idle, latch cleared", 8'h00);
      rd_chk(11'h03E, 2, "R6 bytes before wrap");
      rd_chk(11'h020, 2, "R6 bytes after in-page wrap");
      rd_chk(11'h100, 1, "R8 dropped write left array");

      // R3 top-of-array wrap
      wren(); dbuf[0] = 8'h77; wr(11'h000, 1); tick(WCYC + 50);
      wren(); dbuf[0] = 8'h5A; dbuf[1] = 8'hA5; dbuf[2] = 8'hC3;
      wr(11'h7FE, 3); tick(WCYC + 50);
      rd_chk(11'h7FE, 4, "R3 read wrap 0x7FF to 0x000");
      mode3 = 1'b1;
      rd_chk(11'h7E0, 1, "R1 mode 3 read of wrapped byte");
      mode3 = 1'b0;

      // R9 quarter lock with freeze enable
      wren(); wrsr(8'h84); tick(WCYC + 50); m_wel = 1'b0; m_bp = 2'b01;
      rdsr_chk("R7 status written, latch cleared", 8'h84);
      wren(); dbuf[0] = 8'h12; wr(11'h600, 1); tick(WCYC + 50);
      rd_chk(11'h600, 1, "R9 quarter lock discards");
      wren(); dbuf[0] = 8'h34; wr(11'h5FF, 1); tick(WCYC + 50);
      rd_chk(11'h5FF, 1, "R9 below quarter lock writes");

      // R10 hold-off pin
      wp_n = 1'b0;
      wren(); wrsr(8'h00); tick(20);
      rdsr_chk("R10 frozen status unchanged", 8'h86);
      cmd1(8'h04); m_wel = 1'b0;
      wp_n = 1'b1;
      wren(); wrsr(8'h08); tick(WCYC + 50); m_wel = 1'b0; m_bp = 2'b10;
      rdsr_chk("R10 status writable with pin high", 8'h08);

      // random rounds
      for (int it = 0; it < 6; it++) begin
         logic [1:0]  bp;
         logic [10:0] a;
         int          n;
         mode3 = it[0];
         bp = 2'($urandom_range(0, 3));
         wren(); wrsr({4'b0, bp, 2'b00}); tick(WCYC + 50); m_wel = 1'b0; m_bp = bp;
         rdsr_chk("R4 random status", {4'b0, bp, 2'b00});
         a = 11'($urandom_range(0, 2047));
         n = $urandom_range(1, 36);
         for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
         wren(); wr(a, n); tick(WCYC + 50);
         rd_chk({a[10:5], 5'b0}, 32, "R9 random page round");
      end

      // R9 whole-array lock
      mode3 = 1'b0;
      wren(); wrsr(8'h0C); tick(WCYC + 50); m_wel = 1'b0; m_bp = 2'b11;
      wren(); dbuf[0] = 8'h99; wr(11'h000, 1); tick(WCYC + 50);
      rd_chk(11'h000, 1, "R9 full lock discards");
      rdsr_chk("R9 latch cleared after locked write", 8'h0C);

      finish_run();
   end
endmodule